// File: doc/BRIEF.md
# Set/Clear Register GPIO Controller

This block controls a bank of general-purpose pins from a plain word-wide register bus (address, write strobe, read strobe, write data and read data). Every setting a pin can carry is held in a status word that software changes only through a pair of write-only strobes: one sets the bits written as 1 and the other clears them. A write therefore changes only the pins it names, and software never needs to read a register, modify it and write it back. The settings cover pin enable, output enable, the input glitch filter, the interrupt mask, peripheral A/B selection and a per-bit output write gate. Multi-driver and pull-up settings are stored as status bits only and drive nothing.

Output data is changed through a set strobe, a clear strobe or a direct write. A direct write reaches only the bits whose write gate is open. The live pin levels can be read back at any time. Each pin's input level can pass through a two-clock glitch filter. A change of that level latches a bit in an interrupt status word, which clears when it is read. The interrupt line is asserted while any latched bit is also unmasked.

There is no sequencing state machine. Every register is a plain set/clear word, updated in the same cycle as the write strobe.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, every status word reads zero: pin enable (0x08), output enable (0x18), filter (0x28), output data (0x38), interrupt mask (0x48), interrupt status (0x4C), multi-driver (0x58), pull-up (0x68), A/B select (0x78) and write gate (0xA8). `pin_oe` and `irq` are low after reset.
- R2: Each setting has a set strobe, a clear strobe and a status word. Writing the set strobe ORs `bus_wdata` into the status word, and writing the clear strobe removes the bits written as 1. The offsets as (set, clear, status) are: pin enable (0x00, 0x04, 0x08), output enable (0x10, 0x14, 0x18), filter (0x20, 0x24, 0x28), interrupt mask (0x40, 0x44, 0x48), multi-driver (0x50, 0x54, 0x58), pull-up (0x64, 0x60, 0x68), A/B select (0x74, 0x70, 0x78) and write gate (0xA0, 0xA4, 0xA8).
- R3: `pin_oe[i]` is high only while bit i is set in both the pin-enable status and the output-enable status.
- R4: A write to 0x30 sets to 1 every output data bit written as 1. A write to 0x34 clears those bits. Bits written as 0 are unchanged. `pin_out` shows the output data, and 0x38 reads it back.
- R5: A write to 0x38 replaces only the output data bits that are set in the write-gate status (0xA8). All other bits keep their value.
- R6: A read of 0x3C returns the present `pin_in` levels.
- R7: Set and clear strobe offsets read zero. The unused offsets 0x1C, 0x2C, 0x5C and 0x7C through 0x9C also read zero.
- R8: When an unfiltered input changes, its bit in interrupt status (0x4C) is set on the second rising edge after the change, whatever the mask.
- R9: A read of 0x4C returns the status and clears it at the next clock edge. A change detected at that same edge is kept.
- R10: `irq` is high exactly while some bit is set in both interrupt status and interrupt mask. A masked-off change sets status but leaves `irq` low.
- R11: On a filtered pin, a level must be sampled on two consecutive edges before it passes. A one-cycle pulse causes no interrupt, and a held change sets status one cycle later than on an unfiltered pin (third edge).
- R12: In the A/B select status, 1 means peripheral B. Offset 0x74 sets bits to B and offset 0x70 returns them to A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; qualifies the interrupt status clear |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, combinational from `bus_addr` |
| pin_in | input | PINS | Pin levels from the pads |
| pin_out | output | PINS | Output data toward the pads |
| pin_oe | output | PINS | Per-pin drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench toggles an unmasked pin and samples `irq` one and two cycles later. A design that adds or removes a register on the change path shows up as an off-by-one cycle. The same test is repeated on a filtered pin, where a single-cycle pulse must leave status empty. A filter that only delays the level instead of requiring stability would let that pulse through. Status is read twice in a row: a design that does not clear on read returns the same bits on the second read, and one that clears on any access loses events. Direct writes to 0x38 with the gate partly open show whether the design leaks into gated bits. Outputs enabled on pins that are not pin-enabled show whether the design ignores the enable intersection.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    typedef enum logic [2:0] {
        BK_PEN  = 3'd0,
        BK_DRV  = 3'd1,
        BK_FLT  = 3'd2,
        BK_IMSK = 3'd3,
        BK_MDRV = 3'd4,
        BK_PULL = 3'd5,
        BK_SELB = 3'd6,
        BK_OWR  = 3'd7
    } bank_e;

    localparam int NBANK = 8;

    localparam int unsigned OF_OSET  = 32'h30;
    localparam int unsigned OF_OCLR  = 32'h34;
    localparam int unsigned OF_ODAT  = 32'h38;
    localparam int unsigned OF_PLVL  = 32'h3C;
    localparam int unsigned OF_IRQST = 32'h4C;

    function automatic int unsigned on_ofs(input int b);
        case (b)
            0: return 32'h00;
            1: return 32'h10;
            2: return 32'h20;
            3: return 32'h40;
            4: return 32'h50;
            5: return 32'h64;
            6: return 32'h74;
            7: return 32'hA0;
            default: return 32'hFF;
        endcase
    endfunction

    function automatic int unsigned off_ofs(input int b);
        case (b)
            0: return 32'h04;
            1: return 32'h14;
            2: return 32'h24;
            3: return 32'h44;
            4: return 32'h54;
            5: return 32'h60;
            6: return 32'h70;
            7: return 32'hA4;
            default: return 32'hFF;
        endcase
    endfunction

    function automatic int unsigned st_ofs(input int b);
        case (b)
            0: return 32'h08;
            1: return 32'h18;
            2: return 32'h28;
            3: return 32'h48;
            4: return 32'h58;
            5: return 32'h68;
            6: return 32'h78;
            7: return 32'hA8;
            default: return 32'hFF;
        endcase
    endfunction

endpackage

// File: rtl/setclr_bank.sv
module setclr_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         on_stb,
    input  logic         off_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] stat
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else if (on_stb) begin
            stat <= stat | bits;
        end else if (off_stb) begin
            stat <= stat & ~bits;
        end
    end

endmodule

// File: rtl/input_deglitch.sv
module input_deglitch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] filt_en,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_chg
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic samp, prev, nxt;

        // Filtered pins accept a level only when two successive samples agree.
        always_comb begin
            if (filt_en[i]) begin
                nxt = (samp == prev) ? samp : lvl[i];
            end else begin
                nxt = samp;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                samp   <= 1'b0;
                prev   <= 1'b0;
                lvl[i] <= 1'b0;
            end else begin
                samp   <= pin_in[i];
                prev   <= samp;
                lvl[i] <= nxt;
            end
        end

        assign lvl_chg[i] = nxt ^ lvl[i];
    end

endmodule

// File: rtl/change_irq.sv
module change_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] chg,
    input  logic         rd_clr,
    input  logic [W-1:0] mask,
    output logic [W-1:0] isr,
    output logic         irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr <= '0;
        end else if (rd_clr) begin
            isr <= chg;
        end else begin
            isr <= isr | chg;
        end
    end

    assign irq = |(isr & mask);

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);

    logic [PINS-1:0] bank_st [NBANK];
    logic [PINS-1:0] pen_stat, wr_stat;
    logic [PINS-1:0] odr_q;
    logic [PINS-1:0] lvl_q, lvl_chg, isr_q;
    logic            isr_rd;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic on_w, off_w;
        assign on_w  = bus_we && (bus_addr == ADDR_W'(on_ofs(b)));
        assign off_w = bus_we && (bus_addr == ADDR_W'(off_ofs(b)));
        setclr_bank #(.W(PINS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .on_stb  (on_w),
            .off_stb (off_w),
            .bits    (bus_wdata),
            .stat    (bank_st[b])
        );
    end

    assign pen_stat = bank_st[BK_PEN];
    assign wr_stat  = bank_st[BK_OWR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odr_q <= '0;
        end else if (bus_we && bus_addr == ADDR_W'(OF_OSET)) begin
            odr_q <= odr_q | bus_wdata;
        end else if (bus_we && bus_addr == ADDR_W'(OF_OCLR)) begin
            odr_q <= odr_q & ~bus_wdata;
        end else if (bus_we && bus_addr == ADDR_W'(OF_ODAT)) begin
            odr_q <= (odr_q & ~wr_stat) | (bus_wdata & wr_stat);
        end
    end

    assign pin_out = odr_q;
    assign pin_oe  = pen_stat & bank_st[BK_DRV];

    input_deglitch #(.W(PINS)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .filt_en (bank_st[BK_FLT]),
        .lvl     (lvl_q),
        .lvl_chg (lvl_chg)
    );

    assign isr_rd = bus_re && (bus_addr == ADDR_W'(OF_IRQST));

    change_irq #(.W(PINS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg    (lvl_chg),
        .rd_clr (isr_rd),
        .mask   (bank_st[BK_IMSK]),
        .isr    (isr_q),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == ADDR_W'(st_ofs(b))) begin
                bus_rdata = bank_st[b];
            end
        end
        if (bus_addr == ADDR_W'(OF_ODAT))  bus_rdata = odr_q;
        if (bus_addr == ADDR_W'(OF_PLVL))  bus_rdata = pin_in;
        if (bus_addr == ADDR_W'(OF_IRQST)) bus_rdata = isr_q;
    end

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   pen_st,
    input logic [PINS-1:0]   wr_st,
    input logic [PINS-1:0]   isr,
    input logic [PINS-1:0]   lvl_chg
);

    // R3
    oe_needs_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~pen_st) == '0);

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OF_OSET)) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OF_OCLR)) |=> ((pin_out & $past(bus_wdata)) == '0));

    // R5
    odat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OF_ODAT)) |=> (((pin_out ^ $past(pin_out)) & ~$past(wr_st)) == '0));

    // R8
    chg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_chg != '0) |=> ((isr & $past(lvl_chg)) == $past(lvl_chg)));

    // R9
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(OF_IRQST) && lvl_chg == '0) |=> (isr == '0));

    // R7
    wo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(on_ofs(0)) || bus_addr == ADDR_W'(OF_OSET)) |-> (bus_rdata == '0));

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pen_st    (pen_stat),
    .wr_st     (wr_stat),
    .isr       (isr_q),
    .lvl_chg   (lvl_chg)
);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pinbank_ctrl u_pinbank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'hFC;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0; bus_addr = 8'hFC;
    endtask

    task automatic clear_isr();
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rd(8'h4C, v);
    endtask

    task automatic t_reset();
        logic [7:0] st[10] = '{8'h08, 8'h18, 8'h28, 8'h38, 8'h48, 8'h4C, 8'h58, 8'h68, 8'h78, 8'hA8};
        logic [31:0] v;
        foreach (st[k]) begin
            rd(st[k], v);
            check("R1 reset status", v, 32'h0);
        end
        check("R1 reset pin_oe", pin_oe, 32'h0);
        check("R1 reset irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_triplets();
        logic [7:0] on_l[8]  = '{8'h00, 8'h10, 8'h20, 8'h40, 8'h50, 8'h64, 8'h74, 8'hA0};
        logic [7:0] off_l[8] = '{8'h04, 8'h14, 8'h24, 8'h44, 8'h54, 8'h60, 8'h70, 8'hA4};
        logic [7:0] st_l[8]  = '{8'h08, 8'h18, 8'h28, 8'h48, 8'h58, 8'h68, 8'h78, 8'hA8};
        logic [31:0] v;
        foreach (on_l[k]) begin
            wr(on_l[k], 32'hF0F0_1234);
            wr(on_l[k], 32'h0000_0100);
            rd(st_l[k], v);
            check("R2 set strobe ORs", v, 32'hF0F0_1334);
            wr(off_l[k], 32'h0000_1200);
            rd(st_l[k], v);
            check("R2 clear strobe", v, 32'hF0F0_0134);
            wr(off_l[k], 32'hFFFF_FFFF);
            rd(st_l[k], v);
            check("R2 clear all", v, 32'h0);
        end
    endtask

    task automatic t_oe();
        wr(8'h10, 32'h0FF0_0F00);
        @(negedge clk);
        check("R3 oe without pin enable", pin_oe, 32'h0);
        wr(8'h00, 32'h0000_FF00);
        @(negedge clk);
        check("R3 oe intersection", pin_oe, 32'h0000_0F00);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(8'h30, 32'hFF00_00FF);
        check("R4 set output", pin_out, 32'hFF00_00FF);
        wr(8'h34, 32'h0F00_000F);
        check("R4 clear output", pin_out, 32'hF000_00F0);
        rd(8'h38, v);
        check("R4 read output data", v, 32'hF000_00F0);
    endtask

    task automatic t_direct();
        logic [31:0] v;
        wr(8'h38, 32'h1234_5678);
        check("R5 gate closed", pin_out, 32'hF000_00F0);
        wr(8'hA0, 32'h0000_FFFF);
        wr(8'h38, 32'h1234_5678);
        rd(8'h38, v);
        check("R5 gated write", v, 32'hF000_5678);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        rd(8'h3C, v);
        check("R6 pin level", v, 32'hDEAD_BEEF);
        clear_isr();
    endtask

    task automatic t_wo_zero();
        logic [7:0] z[8] = '{8'h00, 8'h30, 8'h34, 8'h1C, 8'h2C, 8'h5C, 8'h7C, 8'h9C};
        logic [31:0] v;
        wr(8'h00, 32'h0000_00FF);
        foreach (z[k]) begin
            rd(z[k], v);
            check("R7 write-only or unused reads zero", v, 32'h0);
        end
        wr(8'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(8'h40, 32'h0000_0008);
        clear_isr();
        @(negedge clk);
        pin_in = pin_in ^ 32'h8;
        @(negedge clk);
        check("R8 not yet after one edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq on second edge", {31'h0, irq}, 32'h1);
        rd(8'h4C, v);
        check("R8 status bit", v, 32'h0000_0008);
        rd(8'h4C, v);
        check("R9 cleared by read", v, 32'h0);
        check("R10 irq drops after clear", {31'h0, irq}, 32'h0);
        @(negedge clk);
        pin_in = pin_in ^ 32'h20;
        repeat (3) @(negedge clk);
        check("R10 masked change no irq", {31'h0, irq}, 32'h0);
        rd(8'h4C, v);
        check("R10 masked change sets status", v, 32'h0000_0020);
    endtask

    task automatic t_filter();
        logic [31:0] v;
        wr(8'h20, 32'h0000_0008);
        clear_isr();
        @(negedge clk);
        pin_in = pin_in ^ 32'h8;
        @(negedge clk);
        pin_in = pin_in ^ 32'h8;
        repeat (4) @(negedge clk);
        rd(8'h4C, v);
        check("R11 pulse rejected", v, 32'h0);
        @(negedge clk);
        pin_in = pin_in ^ 32'h8;
        @(negedge clk);
        @(negedge clk);
        check("R11 not passed at second edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R11 passed at third edge", {31'h0, irq}, 32'h1);
        clear_isr();
    endtask

    task automatic t_sel();
        logic [31:0] v;
        wr(8'h74, 32'h0000_0003);
        rd(8'h78, v);
        check("R12 select B", v, 32'h0000_0003);
        wr(8'h70, 32'h0000_0001);
        rd(8'h78, v);
        check("R12 back to A", v, 32'h0000_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_triplets();
        t_oe();
        t_setclr();
        t_direct();
        t_level();
        t_wo_zero();
        t_irq();
        t_filter();
        t_sel();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule